// File: doc/BRIEF.md
# Shutter-Driven Acquisition Sequencer

This block converts a slow, externally driven shutter level into the control signals that an acquisition pipeline needs. Each time the shutter opens, the block first issues a single-cycle clear so that downstream counters and event storage start empty. On the next cycle it raises an internal shutter. While that internal shutter is high, it produces a sample clock at a fixed fraction of the system clock. The sample clock's phase is restarted on every opening, so the first sample edge always lines up with the start of acquisition.

Alongside the sample clock, the block emits a one-cycle strobe at phase zero of every sample period. Downstream logic in the system-clock domain uses this strobe as its enable. A bunch-crossing counter advances once per sample period and gives every sample a time stamp relative to the opening.

When the shutter closes, acquisition stops. The divider and the counter hold their last values, so the final stamp can still be read.

The shutter is asynchronous, so it passes through a flop chain before edge detection. All outputs change only on system-clock edges.

Top module: `acq_sequencer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, clear_o, int_shutter_o, sclk_o and sample_stb_o are 0 and bx_count_o is 0.
- R2: A shutter_i rise that is set up before rising edge k makes clear_o high for exactly the one cycle that follows edge k+2 (two synchroniser flops plus one sequencing register).
- R3: int_shutter_o rises in the cycle right after the clear cycle, provided the synchronised shutter is still high. It is never high together with clear_o.
- R4: While int_shutter_o is high, sample_stb_o is high on the first internal-shutter cycle and then on every DIV_RATIO-th cycle (default 4). It is 0 whenever int_shutter_o is 0. The phase restarts at every opening.
- R5: sclk_o is high for the first DIV_RATIO/2 cycles of each sample period and low for the rest. It is 0 whenever int_shutter_o is 0.
- R6: bx_count_o becomes 0 in the cycle after clear_o. It then increases by one in the cycle after each sample_stb_o, so during the n-th strobe of an acquisition (counting from 0) it reads n.
- R7: bx_count_o is BX_WIDTH bits wide (default 16) and wraps from its all-ones value to 0.
- R8: A shutter_i fall set up before edge m makes int_shutter_o low after edge m+2. From then until the next clear cycle, bx_count_o stays constant and sclk_o and sample_stb_o stay 0.
- R9: A shutter opening so short that the synchronised level is already low during the clear cycle still produces one clear pulse, but int_shutter_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| shutter_i | input | 1 | Asynchronous shutter level, high opens acquisition |
| clear_o | output | 1 | One-cycle clear pulse issued on each opening |
| int_shutter_o | output | 1 | Delayed internal shutter, high during acquisition |
| sclk_o | output | 1 | Divided sample clock level |
| sample_stb_o | output | 1 | One-cycle strobe at sample phase zero |
| bx_count_o | output | BX_WIDTH | Bunch-crossing count of sample periods |

## Verification
The bound checker enforces the following relations on every cycle:
- the clear pulse is a single cycle;
- the internal shutter only rises right after a clear;
- the strobe and the sample clock never appear outside the internal shutter;
- the count resets after a clear, steps by one after each strobe, and holds while the block is idle.

The remaining behaviours depend on the history of the shutter input, so only the bench scenarios can show them:
- the exact three-edge latency from the shutter to the clear;
- the restart of the phase on a reopening at an arbitrary phase;
- the one-cycle glitch that yields a clear without acquisition;
- the wrap of the count.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_CLEAR = 2'd1,
      SEQ_RUN   = 2'd2
   } seq_state_e;

endpackage

// File: rtl/acq_sync.sv
module acq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic sync_o
);

   logic [STAGES-1:0] chain_q;

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i) begin
               if (!rst_ni) chain_q[0] <= 1'b0;
               else         chain_q[0] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i) begin
               if (!rst_ni) chain_q[s] <= 1'b0;
               else         chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/acq_phase_div.sv
module acq_phase_div #(
   parameter int DIV_RATIO = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic restart_i,
   input  logic advance_i,
   output logic phase_zero_o,
   output logic high_half_o
);

   localparam int PH_W = $clog2(DIV_RATIO);

   logic [PH_W-1:0] phase_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)        phase_q <= '0;
      else if (restart_i) phase_q <= '0;
      else if (advance_i) phase_q <= phase_q + 1'b1;
   end

   assign phase_zero_o = (phase_q == '0);
   assign high_half_o  = ~phase_q[PH_W-1];

endmodule

// File: rtl/acq_bx_count.sv
module acq_bx_count #(
   parameter int WIDTH = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             zero_i,
   input  logic             step_i,
   output logic [WIDTH-1:0] count_o
);

   logic [WIDTH-1:0] count_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)     count_q <= '0;
      else if (zero_i) count_q <= '0;
      else if (step_i) count_q <= count_q + 1'b1;
   end

   assign count_o = count_q;

endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
   import acq_seq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DIV_RATIO   = 4,
   parameter int BX_WIDTH    = 16
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                shutter_i,
   output logic                clear_o,
   output logic                int_shutter_o,
   output logic                sclk_o,
   output logic                sample_stb_o,
   output logic [BX_WIDTH-1:0] bx_count_o
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("acq_sequencer: SYNC_STAGES must be at least 2");
      end
      if (DIV_RATIO < 2 || (DIV_RATIO & (DIV_RATIO - 1)) != 0) begin : g_bad_div
         $error("acq_sequencer: DIV_RATIO must be a power of two >= 2");
      end
      if (BX_WIDTH < 2) begin : g_bad_bx
         $error("acq_sequencer: BX_WIDTH must be at least 2");
      end
   endgenerate

   logic       shut_lvl;
   logic       shut_prev_q;
   logic       shut_rise;
   seq_state_e state_q, state_d;
   logic       in_clear, in_run;
   logic       ph_zero, ph_high;

   acq_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (shutter_i),
      .sync_o  (shut_lvl)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) shut_prev_q <= 1'b0;
      else         shut_prev_q <= shut_lvl;
   end

   assign shut_rise = shut_lvl & ~shut_prev_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SEQ_IDLE:  if (shut_rise) state_d = SEQ_CLEAR;
         SEQ_CLEAR: state_d = shut_lvl ? SEQ_RUN : SEQ_IDLE;
         SEQ_RUN:   if (!shut_lvl) state_d = SEQ_IDLE;
         default:   state_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) state_q <= SEQ_IDLE;
      else         state_q <= state_d;
   end

   assign in_clear = (state_q == SEQ_CLEAR);
   assign in_run   = (state_q == SEQ_RUN);

   acq_phase_div #(.DIV_RATIO(DIV_RATIO)) i_div (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .restart_i    (in_clear),
      .advance_i    (in_run),
      .phase_zero_o (ph_zero),
      .high_half_o  (ph_high)
   );

   assign sample_stb_o  = in_run & ph_zero;
   assign sclk_o        = in_run & ph_high;
   assign clear_o       = in_clear;
   assign int_shutter_o = in_run;

   acq_bx_count #(.WIDTH(BX_WIDTH)) i_bx (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .zero_i  (in_clear),
      .step_i  (sample_stb_o),
      .count_o (bx_count_o)
   );

endmodule

// File: rtl/acq_sequencer_chk.sv
module acq_sequencer_chk #(
   parameter int BX_WIDTH = 16
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic                clear_o,
   input logic                int_shutter_o,
   input logic                sclk_o,
   input logic                sample_stb_o,
   input logic [BX_WIDTH-1:0] bx_count_o
);

   // R2
   clear_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_o |=> !clear_o);

   // R3
   int_rise_after_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(int_shutter_o) |-> $past(clear_o));

   // R3
   clear_int_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({clear_o, int_shutter_o}));

   // R4
   stb_inside_shutter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sample_stb_o |-> int_shutter_o);

   // R4
   stb_on_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(int_shutter_o) |-> sample_stb_o);

   // R5
   sclk_inside_shutter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sclk_o |-> int_shutter_o);

   // R6
   bx_zero_after_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_o |=> (bx_count_o == '0));

   // R6
   bx_step_after_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sample_stb_o |=> (bx_count_o == $past(bx_count_o) + 1'b1));

   // R8
   bx_frozen_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!int_shutter_o && !clear_o) |=> $stable(bx_count_o));

endmodule

bind acq_sequencer acq_sequencer_chk #(.BX_WIDTH(BX_WIDTH)) i_acq_sequencer_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .clear_o       (clear_o),
   .int_shutter_o (int_shutter_o),
   .sclk_o        (sclk_o),
   .sample_stb_o  (sample_stb_o),
   .bx_count_o    (bx_count_o)
);

// File: tb/test_acq_sequencer.sv
`timescale 1ns/1ps
module test_acq_sequencer;

   localparam int DIV = 4;
   localparam int BXW = 8;

   logic           clk_i = 1'b0;
   logic           rst_ni = 1'b0;
   logic           shutter_i = 1'b0;
   logic           clear_o, int_shutter_o, sclk_o, sample_stb_o;
   logic [BXW-1:0] bx_count_o;

   int tests = 0;
   int fails = 0;
   int cycles = 0;

   always #2.5 clk_i = ~clk_i;

   acq_sequencer #(.SYNC_STAGES(2), .DIV_RATIO(DIV), .BX_WIDTH(BXW)) i_acq_sequencer (
      .clk_i, .rst_ni, .shutter_i, .clear_o, .int_shutter_o,
      .sclk_o, .sample_stb_o, .bx_count_o
   );

   // reference: mode 0 idle, 1 clear, 2 acquiring
   int       m_mode = 0;
   int       m_ph   = 0;
   int       m_bx   = 0;
   logic     q0 = 0, q1 = 0, q2 = 0;

   function automatic logic exp_clear(int mode);        return mode == 1; endfunction
   function automatic logic exp_int(int mode);          return mode == 2; endfunction
   function automatic logic exp_stb(int mode, int ph);  return mode == 2 && ph == 0; endfunction
   function automatic logic exp_sclk(int mode, int ph); return mode == 2 && ph < DIV/2; endfunction

   always @(posedge clk_i) begin
      cycles <= cycles + 1;
      if (!rst_ni) begin
         m_mode = 0; m_ph = 0; m_bx = 0; q0 = 0; q1 = 0; q2 = 0;
      end else begin
         case (m_mode)
            0: if (q1 && !q2) m_mode = 1;
            1: begin m_bx = 0; m_ph = 0; m_mode = q1 ? 2 : 0; end
            default: begin
               if (m_ph == 0) m_bx = (m_bx + 1) % (1 << BXW);
               m_ph = (m_ph + 1) % DIV;
               if (!q1) m_mode = 0;
            end
         endcase
         q2 = q1; q1 = q0; q0 = shutter_i;
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] expv);
      tests++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, expv, cycles);
      end
   endtask

   logic compare_on = 0;
   always @(negedge clk_i) begin
      if (compare_on) begin
         check("R2 clear",     clear_o,       exp_clear(m_mode));
         check("R3 int",       int_shutter_o, exp_int(m_mode));
         check("R4 strobe",    sample_stb_o,  exp_stb(m_mode, m_ph));
         check("R5 sclk",      sclk_o,        exp_sclk(m_mode, m_ph));
         check("R6 bx",        bx_count_o,    m_bx);
      end
   end

   task automatic wait_cyc(int n);
      for (int i = 0; i < n; i++) @(negedge clk_i);
   endtask

   initial begin : watchdog
      wait (cycles > 150000);
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : stim
      int frozen;
      logic wrap_seen;
      void'($urandom(32'h5eed_1234));
      wait_cyc(3);
      // R1 reset state
      check("R1 clear", clear_o, 0);
      check("R1 int", int_shutter_o, 0);
      check("R1 stb", sample_stb_o, 0);
      check("R1 sclk", sclk_o, 0);
      check("R1 bx", bx_count_o, 0);
      rst_ni = 1'b1;
      @(negedge clk_i);
      check("R1 after release", {clear_o, int_shutter_o, sclk_o, sample_stb_o}, 0);
      compare_on = 1;

      // R2 / R3 / R4 directed latency
      shutter_i = 1'b1;
      @(negedge clk_i); check("R2 latency e1", clear_o, 0);
      @(negedge clk_i); check("R2 latency e2", clear_o, 0);
      @(negedge clk_i); check("R2 latency e3", clear_o, 1);
      @(negedge clk_i);
      check("R2 one cycle", clear_o, 0);
      check("R3 int after clear", int_shutter_o, 1);
      check("R4 first strobe", sample_stb_o, 1);
      check("R6 bx zero", bx_count_o, 0);
      wait_cyc(DIV);
      check("R6 bx one", bx_count_o, 1);
      check("R4 period", sample_stb_o, 1);

      // R8 closing and freezing
      shutter_i = 1'b0;
      wait_cyc(3);
      check("R8 int low", int_shutter_o, 0);
      frozen = bx_count_o;
      wait_cyc(10);
      check("R8 bx frozen", bx_count_o, frozen);
      check("R8 stb idle", sample_stb_o, 0);

      // R9 glitch: one-cycle opening
      shutter_i = 1'b1; @(negedge clk_i); shutter_i = 1'b0;
      wait_cyc(2); check("R9 glitch clear", clear_o, 1);
      @(negedge clk_i); check("R9 no int", int_shutter_o, 0);
      wait_cyc(3);
      check("R9 still idle", int_shutter_o, 0);

      // R7 wrap
      shutter_i = 1'b1;
      wrap_seen = 0;
      for (int i = 0; i < (1 << BXW) * DIV + 40; i++) begin
         @(negedge clk_i);
         if (int_shutter_o && bx_count_o == 0 && i > 20) wrap_seen = 1;
      end
      check("R7 wrap", wrap_seen, 1);
      shutter_i = 1'b0;
      wait_cyc(6);

      // random openings at random phases (R4 phase restart, R6, R8)
      for (int k = 0; k < 60; k++) begin
         shutter_i = 1'b1;
         wait_cyc(1 + ($urandom % 40));
         shutter_i = 1'b0;
         wait_cyc(1 + ($urandom % 12));
      end
      wait_cyc(8);
      compare_on = 0;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule